// File: doc/BRIEF.md
# SDRAM Self-Refresh Exit Sequencer

This block owns the clock-enable pin and the refresh-related command slot of an SDRAM controller while the memory leaves self-refresh. A single-cycle entry request drops the clock enable and issues the self-refresh command. An exit request then starts a gated sequence. The clock enable stays low until the board reports a stable clock. It then rises, and only NOP commands go out for the exit-recovery time. After that a ready flag tells the rest of the controller that normal commands may resume.

Once ready, an interval timer restarts from a full period and asks for one AUTO REFRESH at a fixed parameterized spacing. These refreshes continue the device's internal row counter, which self-refresh shares. All control pins are plain level or pulse signals with no handshake. Requests are sampled on the rising clock edge. The outputs depend only on registered state.

Top module: `sdram_srx_seq`

The command output is `{cs_n, ras_n, cas_n, we_n}`. NOP is `4'b0111` and AUTO REFRESH is `4'b0001`. The AUTO REFRESH code issued with the clock enable low is the self-refresh entry command.

## Requirements
- R1: After reset the block is ready: cke_o=1, ready_o=1, cmd_o=NOP (4'b0111) and refresh_req_o=0.
- R2: An entry request sampled while ready gives, in the next cycle, cke_o=0, ready_o=0 and cmd_o=4'b0001 for exactly one cycle. Later cycles show NOP.
- R3: After entry, cke_o stays low until an exit request has been sampled and clk_stable_i has been sampled high after it. While clk_stable_i is low, cke_o never rises.
- R4: When cke_o rises, the block shows cke_o=1, ready_o=0 and cmd_o=NOP for exactly XSR_CLK cycles, where XSR_CLK = max(2, ceil(TXSR_NS/TCK_NS)). ready_o then rises.
- R5: ready_o is high only while the normal-operation state holds, and then cke_o is high.
- R6: While ready, refresh_req_o pulses for one cycle, with cmd_o=4'b0001, every REF_CLK cycles, where REF_CLK = floor(TREFI_NS/TCK_NS). The first pulse comes REF_CLK cycles after the first ready cycle, so the timer restarts at exit.
- R7: An exit request is ignored unless the block is in self-refresh. An entry request is ignored unless the block is ready.
- R8: If an entry request arrives in the cycle in which the refresh interval expires, entry wins: no refresh_req_o pulse, and the entry command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| clk_stable_i | input | 1 | Memory clock is within its timing limits |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| ready_o | output | 1 | Normal commands may be issued |
| refresh_req_o | output | 1 | One-cycle AUTO REFRESH request |

## Verification
The assertions check the local rules on every cycle. Clock enable never rises while the clock is unstable. A falling clock enable carries the entry command. The first two cycles after it rises are NOP and not ready. Ready implies clock enable. Refresh pulses are single cycles carrying the refresh code. Only the bench's scenarios can show the exact recovery length, the refresh period and its restart at exit, that out-of-state requests are ignored, and that entry wins over a simultaneous timer expiry. The bench covers these by comparing against a cycle model it computes itself.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    SRX_SELF  = 2'd0,
    SRX_WAIT  = 2'd1,
    SRX_NOP   = 2'd2,
    SRX_READY = 2'd3
  } srx_state_e;

  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_AREF = 4'b0001;
endpackage

// File: rtl/srx_fsm.sv
module srx_fsm
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  logic       exit_i,
  input  logic       stable_i,
  input  logic       nop_done_i,
  output srx_state_e state_o,
  output logic       nop_load_o
);
  srx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRX_READY: if (enter_i)    state_d = SRX_SELF;
      SRX_SELF:  if (exit_i)     state_d = SRX_WAIT;
      SRX_WAIT:  if (stable_i)   state_d = SRX_NOP;
      SRX_NOP:   if (nop_done_i) state_d = SRX_READY;
      default:                   state_d = SRX_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SRX_READY;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign nop_load_o = (state_q == SRX_WAIT) && stable_i;
endmodule

// File: rtl/srx_down_timer.sv
module srx_down_timer #(
  parameter int unsigned PERIOD   = 2,
  parameter bit          AUTO_RLD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int unsigned W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [W-1:0] TOP = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= TOP;
    else if (load_i)
      cnt_q <= TOP;
    else if (run_i) begin
      if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      else if (AUTO_RLD) cnt_q <= TOP;
    end
  end

  assign zero_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sdram_srx_seq.sv
module sdram_srx_seq
  import srx_pkg::*;
#(
  parameter int unsigned TCK_NS   = 8,
  parameter int unsigned TXSR_NS  = 70,
  parameter int unsigned TREFI_NS = 15625
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  input  logic       clk_stable_i,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       ready_o,
  output logic       refresh_req_o
);
  localparam int unsigned XSR_RAW = (TXSR_NS + TCK_NS - 1) / TCK_NS;
  localparam int unsigned XSR_CLK = (XSR_RAW < 2) ? 2 : XSR_RAW;
  localparam int unsigned REF_CLK = TREFI_NS / TCK_NS;

  srx_state_e state;
  logic nop_load, nop_done, ref_zero;
  logic in_ready, in_nop;
  logic ent_q, req_q;

  assign in_ready = (state == SRX_READY);
  assign in_nop   = (state == SRX_NOP);

  srx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_i    (sr_enter_i),
    .exit_i     (sr_exit_i),
    .stable_i   (clk_stable_i),
    .nop_done_i (nop_done),
    .state_o    (state),
    .nop_load_o (nop_load)
  );

  srx_down_timer #(.PERIOD(XSR_CLK), .AUTO_RLD(1'b0)) u_xsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (nop_load),
    .run_i  (in_nop),
    .zero_o (nop_done)
  );

  // restart the refresh interval at the moment of exit
  srx_down_timer #(.PERIOD(REF_CLK), .AUTO_RLD(1'b1)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (nop_done),
    .run_i  (in_ready),
    .zero_o (ref_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      ent_q <= in_ready && sr_enter_i;
      req_q <= ref_zero && !sr_enter_i;
    end
  end

  assign cke_o         = in_ready || in_nop;
  assign ready_o       = in_ready;
  assign refresh_req_o = req_q;
  assign cmd_o         = (ent_q || req_q) ? CMD_AREF : CMD_NOP;
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable_i,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic       ready_o,
  input logic       refresh_req_o
);
  // R3
  cke_held_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && !clk_stable_i) |=> !cke_o);
  // R2
  entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (cmd_o == CMD_AREF) && !ready_o);
  // R4
  exit_nop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> !ready_o && (cmd_o == CMD_NOP));
  // R4
  exit_nop_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |=> cke_o && !ready_o && (cmd_o == CMD_NOP));
  // R5
  ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> cke_o);
  // R6
  refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |=> !refresh_req_o);
  // R6
  refresh_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |-> (cmd_o == CMD_AREF) && ready_o);
endmodule

bind sdram_srx_seq srx_chk u_srx_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_stable_i  (clk_stable_i),
  .cke_o         (cke_o),
  .cmd_o         (cmd_o),
  .ready_o       (ready_o),
  .refresh_req_o (refresh_req_o)
);

// File: tb/test_sdram_srx_seq.sv
module test_sdram_srx_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TCK  = 8;
  localparam int TXSR = 5;
  localparam int TREFI = 200;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] AREF = 4'b0001;

  function automatic int xsr_f();
    int r = (TXSR + TCK - 1) / TCK;
    return (r < 2) ? 2 : r;
  endfunction
  function automatic int ref_f();
    return TREFI / TCK;
  endfunction

  logic clk = 0, rst_n = 0;
  logic enter = 0, exit_r = 0, stable = 0;
  logic cke, ready, req;
  logic [3:0] cmd;
  int errors = 0, checks = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_srx_seq #(.TCK_NS(TCK), .TXSR_NS(TXSR), .TREFI_NS(TREFI)) i_sdram_srx_seq (
    .clk(clk), .rst_n(rst_n), .sr_enter_i(enter), .sr_exit_i(exit_r),
    .clk_stable_i(stable), .cke_o(cke), .cmd_o(cmd), .ready_o(ready),
    .refresh_req_o(req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model: 0 self, 1 wait, 2 nop, 3 ready
  int m_st, m_nop, m_ref;
  bit m_req, m_ent;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 3; m_ref <= ref_f() - 1; m_req <= 0; m_ent <= 0; m_nop <= 0;
    end else begin
      m_req <= 0; m_ent <= 0;
      case (m_st)
        3: begin
          m_ent <= enter;
          m_req <= !enter && (m_ref == 0);
          m_ref <= (m_ref == 0) ? ref_f() - 1 : m_ref - 1;
          if (enter) m_st <= 0;
        end
        0: if (exit_r) m_st <= 1;
        1: if (stable) begin m_st <= 2; m_nop <= xsr_f() - 1; end
        default: if (m_nop == 0) begin m_st <= 3; m_ref <= ref_f() - 1; end
                 else m_nop <= m_nop - 1;
      endcase
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R3 cke", cke, (m_st == 3 || m_st == 2));
    chk("R5 ready", ready, (m_st == 3));
    chk("R6 refresh_req", req, m_req);
    chk("R2 cmd", cmd, (m_req || m_ent) ? AREF : NOP);
  end

  task automatic step(bit e, bit x, bit s);
    enter = e; exit_r = x; stable = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cke", cke, 1); chk("R1 ready", ready, 1);
    chk("R1 cmd", cmd, NOP); chk("R1 req", req, 0);
    cmp_on = 1;
    // R7 exit while ready is ignored
    step(0, 1, 1);
    chk("R7 exit ignored ready", ready, 1);
    // R2 entry
    step(1, 0, 0);
    chk("R2 cke low", cke, 0); chk("R2 entry cmd", cmd, AREF);
    step(1, 0, 1); // R7 entry in self-refresh ignored
    chk("R2 cmd back to nop", cmd, NOP);
    chk("R7 enter ignored cke", cke, 0);
    // R3 exit with unstable clock
    step(0, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    chk("R3 cke held low", cke, 0);
    // R4 recovery length
    step(0, 0, 1);
    n = 0;
    while (!ready && n < 100) begin
      if (cke && cmd == NOP) n++;
      step(0, 0, 0);
    end
    chk("R4 nop cycles", n, xsr_f());
    // R6 first refresh after exit, then period
    n = 0;
    while (!req && n < 1000) begin n++; step(0, 0, 0); end
    chk("R6 first interval", n, ref_f());
    step(0, 0, 0);
    n = 1;
    while (!req && n < 1000) begin n++; step(0, 0, 0); end
    chk("R6 period", n, ref_f());
    // R8 entry at expiry: in cycle 0 of interval now; move to cycle REF-1
    for (int i = 0; i < ref_f() - 1; i++) step(0, 0, 0);
    step(1, 0, 0);
    chk("R8 no refresh", req, 0); chk("R8 entry cmd", cmd, AREF);
    chk("R8 cke low", cke, 0);
    // random phase
    for (int i = 0; i < 20000; i++)
      step(($urandom % 64) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule